// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two single-precision binary floating-point words and returns their rounded product. Each operand word holds a sign in bit 31, a biased exponent in bits 30:23 and a fraction in bits 22:0, and its value is 1.f × 2^(e−127). The block splits each operand into these fields and puts back the hidden leading one. It multiplies the two 24-bit significands into a 48-bit product and builds the result exponent by adding the two biased exponents and taking one bias away. It then normalises the product by at most one place and rounds it to 24 bits, sending an exact halfway case to the even neighbour.

Zero, infinity and NaN encodings are handled on a separate path. An input with a zero exponent field counts as zero, whatever its fraction holds, and a result too small for a normal number becomes a signed zero. The field widths are parameters, so the same RTL can be built at a reduced width for exhaustive checking.

The block is a two-stage pipeline. Operands come in with a valid flag. Two clock edges later the result comes out with its own valid flag. A new operand pair may be accepted on every cycle.

Top module: `fp_mul_sp`

## Requirements
- R1: For normal operands whose product stays in range, the result equals the exact product of the two values rounded to the nearest representable value. The exponent field is e1 + e2 − 127 before any adjustment, so −8.0 (0xC1000000) times 16.0 (0x41800000) gives 0xC3000000.
- R2: On every path except NaN, the result sign bit (bit 31) is the XOR of the two operand sign bits.
- R3: When the significand product is 2.0 or more, it is shifted right by one place and the exponent is raised by one before rounding. 1.5 × 1.5 gives 0x40100000.
- R4: Rounding is to nearest with ties to even. If rounding carries out of the significand, the fraction becomes zero and the exponent rises by one. 0x3F800001 × 0x3FC00000 gives 0x3FC00002.
- R5: A finite product whose final exponent, after normalising and rounding, exceeds 254 gives an infinity with the product's sign: exponent field all ones, fraction zero.
- R6: A finite product whose final exponent is below 1 gives a zero with the product's sign. An operand whose exponent field is 0 is treated as zero, whatever its fraction.
- R7: If either operand is a NaN (exponent field all ones, fraction nonzero), or if zero is multiplied by infinity, the result is the canonical quiet NaN: sign 0, exponent all ones, fraction MSB 1 and all other fraction bits 0 (0x7FC00000).
- R8: Infinity times a nonzero operand that is not a NaN gives an infinity with the product's sign. Zero times a finite operand gives a zero with the product's sign.
- R9: `out_valid` repeats `in_valid` two clock edges later, and `result` in that cycle belongs to the operands presented with it. Pairs may be issued back to back or with gaps.
- R10: While reset is active and on the first two edges after it, `out_valid` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair on `op_a`/`op_b` is valid this cycle |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| out_valid | output | 1 | `result` is valid this cycle |
| result | output | 32 | Rounded product word |

## Verification
A fault in the first pipeline stage, such as a wrong special-case class, a bad exponent sum or a damaged significand product, shows up at `result` exactly two cycles after the operand pair that caused it. It affects only that one pair, because the pipeline carries nothing from one operation to the next. Rounding and normalisation faults usually change only the last fraction bit or the exponent by one, and only for operands that hit a tie or a carry. For that reason the bench sweeps every operand pair of an 8-bit build (4-bit exponent, 3-bit fraction) against an arithmetic model, and it also checks the full-width build on directed corner cases. A valid-path fault shows up as `out_valid` arriving a cycle early or late, or being lost across the gaps that the sweep inserts.

// File: rtl/fpm_pkg.sv
// Shared types for the floating-point multiplier.
// Assumes nothing beyond the parameters of the modules that import it.
package fpm_pkg;

    // Operand class after unpacking; denormals already folded into ZERO.
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fpm_class_e;

    // Special-case outcome chosen in the first stage for a whole operation.
    typedef enum logic [1:0] {
        SPEC_NONE = 2'd0,
        SPEC_ZERO = 2'd1,
        SPEC_INF  = 2'd2,
        SPEC_NAN  = 2'd3
    } fpm_spec_e;

endpackage

// File: rtl/fpm_unpack.sv
// Operand unpacker: splits a word into sign, biased exponent and a
// significand with the hidden one restored, and classifies it.
// Assumes FRAC_W >= 1. A zero exponent field is classed ZERO, so
// denormal encodings are flushed.
module fpm_unpack
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    output logic                  sign,
    output logic [EXP_W-1:0]      expo,
    output logic [FRAC_W:0]       sig,
    output fpm_class_e            cls
);

    localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};

    logic [FRAC_W-1:0] frac;
    logic              exp_max;
    logic              exp_min;
    logic              frac_nz;

    // Field split and hidden-bit restore.
    always_comb begin
        sign = word[EXP_W+FRAC_W];
        expo = word[EXP_W+FRAC_W-1:FRAC_W];
        frac = word[FRAC_W-1:0];
        sig  = {1'b1, frac};
    end

    // Classification of the encoding.
    always_comb begin
        exp_max = (expo == EXP_ONES);
        exp_min = (expo == '0);
        frac_nz = |frac;
        if (exp_max && frac_nz) begin
            cls = CLS_NAN;
        end else if (exp_max) begin
            cls = CLS_INF;
        end else if (exp_min) begin
            cls = CLS_ZERO;
        end else begin
            cls = CLS_NORM;
        end
    end

endmodule

// File: rtl/fpm_sigmul.sv
// Significand multiplier: unsigned SIG_W x SIG_W product, full width.
// Assumes both inputs carry their leading one, so the product top two
// bits are never both zero.
module fpm_sigmul #(
    parameter int SIG_W = 24
) (
    input  logic [SIG_W-1:0]   sig_a,
    input  logic [SIG_W-1:0]   sig_b,
    output logic [2*SIG_W-1:0] prod
);

    localparam int PROD_W = 2 * SIG_W;

    logic [PROD_W-1:0] ext_a;
    logic [PROD_W-1:0] ext_b;

    // Zero-extend and multiply at product width.
    always_comb begin
        ext_a = PROD_W'(sig_a);
        ext_b = PROD_W'(sig_b);
        prod  = ext_a * ext_b;
    end

endmodule

// File: rtl/fpm_round.sv
// Normalise, round and range-check a finite product.
// Input exponent is the signed biased sum e1 + e2 - bias. Output is a
// packed word: a normal number, signed infinity on overflow, or signed
// zero when the rounded exponent falls below 1. Ties go to even.
module fpm_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                     sign,
    input  logic signed [EXP_W+1:0]  exp_in,
    input  logic [2*FRAC_W+1:0]      prod,
    output logic [EXP_W+FRAC_W:0]    word
);

    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int EXT_W  = EXP_W + 2;
    localparam logic signed [EXT_W-1:0] EMAX_X = EXT_W'((1 << EXP_W) - 2);

    logic                    top;
    logic [PROD_W-1:0]       norm;
    logic [SIG_W-1:0]        keep;
    logic                    guard;
    logic                    sticky;
    logic                    rnd_up;
    logic [SIG_W:0]          rnd;
    logic                    carry;
    logic signed [EXT_W-1:0] e_fin;
    logic [FRAC_W-1:0]       frac_fin;
    logic                    ovf;
    logic                    unf;
    logic                    unused_hid;

    // One-place normalisation and guard/sticky extraction.
    always_comb begin
        top    = prod[PROD_W-1];
        norm   = top ? prod : (prod << 1);
        keep   = norm[PROD_W-1 -: SIG_W];
        guard  = norm[SIG_W-1];
        sticky = |norm[SIG_W-2:0];
    end

    // Round to nearest, ties to even; carry-out renormalises.
    always_comb begin
        rnd_up     = guard & (sticky | keep[0]);
        rnd        = {1'b0, keep} + {{SIG_W{1'b0}}, rnd_up};
        carry      = rnd[SIG_W];
        unused_hid = rnd[SIG_W-1];
        frac_fin   = carry ? '0 : rnd[FRAC_W-1:0];
    end

    // Final exponent and range decision.
    always_comb begin
        e_fin = exp_in
              + $signed({{(EXT_W-1){1'b0}}, top})
              + $signed({{(EXT_W-1){1'b0}}, carry});
        ovf   = (e_fin > EMAX_X);
        unf   = e_fin[EXT_W-1] || (e_fin == '0);
    end

    // Output packing.
    always_comb begin
        if (ovf) begin
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (unf) begin
            word = {sign, {(EXP_W+FRAC_W){1'b0}}};
        end else begin
            word = {sign, e_fin[EXP_W-1:0], frac_fin};
        end
    end

endmodule

// File: rtl/fp_mul_sp.sv
// Floating-point multiplier, two-stage pipeline.
// Stage 1: unpack, classify, exponent sum, significand product.
// Stage 2: normalise, round, range check, special-value select.
// Assumes EXP_W >= 3 and FRAC_W >= 2. Synchronous active-low reset
// clears valid and data registers. Throughput is one pair per cycle.
module fp_mul_sp
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [EXP_W+FRAC_W:0]  op_a,
    input  logic [EXP_W+FRAC_W:0]  op_b,
    output logic                   out_valid,
    output logic [EXP_W+FRAC_W:0]  result
);

    localparam int W      = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int EXT_W  = EXP_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam logic signed [EXT_W-1:0] BIAS_X = EXT_W'(BIAS);
    localparam logic [W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    // Stage-1 combinational signals
    logic              sa, sb;
    logic [EXP_W-1:0]  ea, eb;
    logic [SIG_W-1:0]  ma, mb;
    fpm_class_e        ca, cb;
    logic [PROD_W-1:0] prod_c;
    logic signed [EXT_W-1:0] exp_c;
    fpm_spec_e         spec_c;

    // Stage-1 registers
    logic                    v1;
    logic                    sign1;
    logic signed [EXT_W-1:0] exp1;
    logic [PROD_W-1:0]       prod1;
    fpm_spec_e               spec1;

    // Stage-2 signals and registers
    logic [W-1:0] fin_word;
    logic [W-1:0] sel_word;
    logic         v2;
    logic [W-1:0] res2;

    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_a (
        .word (op_a),
        .sign (sa),
        .expo (ea),
        .sig  (ma),
        .cls  (ca)
    );

    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_b (
        .word (op_b),
        .sign (sb),
        .expo (eb),
        .sig  (mb),
        .cls  (cb)
    );

    fpm_sigmul #(.SIG_W(SIG_W)) u_sigmul (
        .sig_a (ma),
        .sig_b (mb),
        .prod  (prod_c)
    );

    // Biased exponent sum with one bias removed, in signed extended width.
    always_comb begin
        exp_c = $signed({2'b00, ea}) + $signed({2'b00, eb}) - BIAS_X;
    end

    // Special-case priority: NaN (incl. zero x inf), then inf, then zero.
    always_comb begin
        if (ca == CLS_NAN || cb == CLS_NAN ||
            (ca == CLS_ZERO && cb == CLS_INF) ||
            (ca == CLS_INF && cb == CLS_ZERO)) begin
            spec_c = SPEC_NAN;
        end else if (ca == CLS_INF || cb == CLS_INF) begin
            spec_c = SPEC_INF;
        end else if (ca == CLS_ZERO || cb == CLS_ZERO) begin
            spec_c = SPEC_ZERO;
        end else begin
            spec_c = SPEC_NONE;
        end
    end

    // Stage-1 pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1    <= 1'b0;
            sign1 <= 1'b0;
            exp1  <= '0;
            prod1 <= '0;
            spec1 <= SPEC_NONE;
        end else begin
            v1    <= in_valid;
            sign1 <= sa ^ sb;
            exp1  <= exp_c;
            prod1 <= prod_c;
            spec1 <= spec_c;
        end
    end

    fpm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .sign   (sign1),
        .exp_in (exp1),
        .prod   (prod1),
        .word   (fin_word)
    );

    // Final selection between finite path and special encodings.
    always_comb begin
        unique case (spec1)
            SPEC_NAN:  sel_word = QNAN;
            SPEC_INF:  sel_word = {sign1, INF_MAG};
            SPEC_ZERO: sel_word = {sign1, {(W-1){1'b0}}};
            default:   sel_word = fin_word;
        endcase
    end

    // Stage-2 pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2   <= 1'b0;
            res2 <= '0;
        end else begin
            v2   <= v1;
            res2 <= sel_word;
        end
    end

    assign out_valid = v2;
    assign result    = res2;

    // R9
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R9
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R7
    nan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v1 && spec1 == SPEC_NAN) |=> (result == QNAN));

    // R8
    inf_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v1 && spec1 == SPEC_INF) |=>
            (result[W-2:0] == INF_MAG) && (result[W-1] == $past(sign1)));

    // R2
    sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v1 && spec1 != SPEC_NAN) |=> (result[W-1] == $past(sign1)));

    // R5
    no_fin_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v1 && spec1 == SPEC_NONE) |=>
            (result[W-2:FRAC_W] != {EXP_W{1'b1}}) || (result[FRAC_W-1:0] == '0));

endmodule

// File: tb/fp_mul_sp_bench.sv
// Bench: exhaustive sweep of an 8-bit build (4-bit exponent, 3-bit
// fraction) against an arithmetic model, plus directed checks on the
// full-width build.
module fp_mul_sp_bench;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Small build
    logic       s_in_valid = 1'b0;
    logic [7:0] s_a = '0, s_b = '0;
    logic       s_out_valid;
    logic [7:0] s_res;

    fp_mul_sp #(.EXP_W(4), .FRAC_W(3)) u_fp_mul_sp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s_in_valid),
        .op_a      (s_a),
        .op_b      (s_b),
        .out_valid (s_out_valid),
        .result    (s_res)
    );

    // Full-width build
    logic        w_in_valid = 1'b0;
    logic [31:0] w_a = '0, w_b = '0;
    logic        w_out_valid;
    logic [31:0] w_res;

    fp_mul_sp u_fp_mul_sp_w32 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (w_in_valid),
        .op_a      (w_a),
        .op_b      (w_b),
        .out_valid (w_out_valid),
        .result    (w_res)
    );

    int n_chk = 0;
    int n_bad = 0;
    int n_print = 0;
    bit done = 1'b0;

    // Bench copy of the issued pairs, two deep.
    logic       q1_v = 1'b0, q2_v = 1'b0;
    logic [7:0] q1_a = '0, q1_b = '0, q2_a = '0, q2_b = '0;

    task automatic check(input int req, input logic [31:0] got,
                         input logic [31:0] exp_v, input string what);
        n_chk++;
        if (got !== exp_v) begin
            n_bad++;
            if (n_print < 30) begin
                n_print++;
                $display("FAIL R%0d %s got=%h exp=%h", req, what, got, exp_v);
            end
        end
    endtask

    // Arithmetic model for the 8-bit build (bias 7, max normal exponent 14).
    function automatic void ref_mul(input logic [7:0] a, input logic [7:0] b,
                                    output logic [7:0] r, output int tag);
        logic s;
        bit a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
        int p, q, rem, half, sh, e;
        s      = a[7] ^ b[7];
        a_nan  = (a[6:3] == 4'hF) && (a[2:0] != 0);
        b_nan  = (b[6:3] == 4'hF) && (b[2:0] != 0);
        a_inf  = (a[6:3] == 4'hF) && (a[2:0] == 0);
        b_inf  = (b[6:3] == 4'hF) && (b[2:0] == 0);
        a_zero = (a[6:3] == 4'h0);
        b_zero = (b[6:3] == 4'h0);
        if (a_nan || b_nan || (a_zero && b_inf) || (a_inf && b_zero)) begin
            r = 8'h7C; tag = 7;                       // R7
        end else if (a_inf || b_inf) begin
            r = {s, 7'h78}; tag = 8;                  // R8
        end else if (a_zero || b_zero) begin
            r = {s, 7'h00}; tag = 8;                  // R8 / R6
        end else begin
            p = (8 + int'(a[2:0])) * (8 + int'(b[2:0]));
            e = int'(a[6:3]) + int'(b[6:3]) - 7;
            if (p >= 128) begin sh = 4; e = e + 1; end else sh = 3;
            q    = p >> sh;
            rem  = p - (q << sh);
            half = 1 << (sh - 1);
            if (rem > half || (rem == half && (q % 2) == 1)) q = q + 1;
            if (q == 16) begin q = 8; e = e + 1; end
            if (e > 14) begin
                r = {s, 7'h78}; tag = 5;              // R5
            end else if (e < 1) begin
                r = {s, 7'h00}; tag = 6;              // R6
            end else begin
                r = {s, e[3:0], q[2:0]};
                if (rem != 0) tag = 4;                // R4
                else if (sh == 4) tag = 3;            // R3
                else tag = 1;                         // R1
            end
        end
    endfunction

    // One cycle of the small build: check the pair issued two cycles ago.
    task automatic step(input logic v, input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r;
        int tag;
        @(negedge clk);
        // R9: valid delayed by two edges
        check(9, {31'b0, s_out_valid}, {31'b0, q2_v}, "valid");
        if (q2_v) begin
            ref_mul(q2_a, q2_b, r, tag);
            check(tag, {24'b0, s_res}, {24'b0, r}, $sformatf("a=%h b=%h", q2_a, q2_b));
            if (tag != 7) begin
                // R2: sign is XOR of operand signs
                check(2, {31'b0, s_res[7]}, {31'b0, q2_a[7] ^ q2_b[7]}, "sign");
            end
        end
        q2_v = q1_v; q2_a = q1_a; q2_b = q1_b;
        q1_v = v;    q1_a = a;    q1_b = b;
        s_in_valid = v; s_a = a; s_b = b;
    endtask

    task automatic wide(input int req, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] exp_v);
        @(negedge clk);
        w_in_valid = 1'b1; w_a = a; w_b = b;
        @(negedge clk);
        w_in_valid = 1'b0;
        @(negedge clk);
        check(9, {31'b0, w_out_valid}, 32'd1, "wide valid");
        check(req, w_res, exp_v, $sformatf("wide a=%h b=%h", a, b));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(10, {31'b0, s_out_valid}, 32'd0, "reset valid");
        check(10, {24'b0, s_res}, 32'd0, "reset result");
        check(10, {31'b0, w_out_valid}, 32'd0, "reset valid wide");
        check(10, w_res, 32'd0, "reset result wide");
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(10, {31'b0, w_out_valid}, 32'd0, "post-reset valid");
        check(10, w_res, 32'd0, "post-reset result");

        // Directed full-width cases
        wide(1, 32'hC1000000, 32'h41800000, 32'hC3000000);   // R1 -8 x 16
        wide(3, 32'h3FC00000, 32'h3FC00000, 32'h40100000);   // R3 1.5 x 1.5
        wide(4, 32'h3F800001, 32'h3FC00000, 32'h3FC00002);   // R4 tie to even
        wide(5, 32'h7F000000, 32'h40000000, 32'h7F800000);   // R5 overflow
        wide(6, 32'h80800000, 32'h3F000000, 32'h80000000);   // R6 underflow
        wide(6, 32'h00400000, 32'h3F800000, 32'h00000000);   // R6 denormal in
        wide(7, 32'h7F800001, 32'h3F800000, 32'h7FC00000);   // R7 NaN in
        wide(7, 32'h00000000, 32'hFF800000, 32'h7FC00000);   // R7 zero x inf
        wide(8, 32'h7F800000, 32'hC0000000, 32'hFF800000);   // R8 inf x -2
        wide(2, 32'hBF800000, 32'hBF800000, 32'h3F800000);   // R2 -1 x -1

        // Exhaustive sweep of the small build with periodic gaps (R9)
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                if ((b % 13) == 0) step(1'b0, 8'h00, 8'h00);
                step(1'b1, 8'(a), 8'(b));
            end
        end
        step(1'b0, 8'h00, 8'h00);
        step(1'b0, 8'h00, 8'h00);
        step(1'b0, 8'h00, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule